// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of an open-drain two-wire bus and, when it is asked, plays out a fixed recovery pattern that brings any stuck target back to idle. A target that lost its place in a transfer, for example after a reset in mid-byte, may still be holding the data line low. The pattern begins with a start condition. It then gives nine clock pulses with the data line released, so the target can shift out the rest of its byte and reach an acknowledge slot. It ends with a second start condition, a stop condition, and a bus-free interval.

The block only drives output enables, and a 1 pulls its line low. A released line is pulled high outside the block. Every phase length is a parameter counted in system clock cycles. Two sets of lengths exist, one for the slower and one for the faster bus speed, and a mode input picks between them when a sequence starts. A single-cycle `done` pulse marks the end. The data line is never read back.

Top module: `bus_recovery_seq`

## Requirements
- R1: While reset is active and whenever the block is idle, `scl_oe` and `sda_oe` are 0 (both lines released) and `done` is 0.
- R2: A `trig` sampled high while idle starts a sequence. On the next edge both lines stay released for the start setup count (SU). After that, `sda_oe` is 1 with `scl_oe` 0 for the start hold count (HD), which forms the first start.
- R3: After the first start, one cycle follows with both enables at 1. Then `sda_oe` drops to 0 and exactly nine clock pulses follow. Each pulse has `scl_oe`=1 for the low count (LO) and `scl_oe`=0 for the high count (HI). `sda_oe` stays 0 through all nine pulses.
- R4: After the ninth high phase, both lines stay released for SU. Then `sda_oe` is 1 with `scl_oe` 0 for HD plus the stop setup count (SO). Then `sda_oe` returns to 0 with `scl_oe` still 0, which forms the stop.
- R5: After the stop, both lines stay released for the bus-free count (BF). `done` is then 1 for exactly one cycle, the cycle after the last bus-free cycle, and the block is idle from that cycle on.
- R6: `fast_mode` sampled with the accepted trigger selects the fast counts when 1 and the slow counts when 0. Changing `fast_mode` during a sequence has no effect on it.
- R7: A `trig` that arrives while a sequence runs is ignored, up to and including the last bus-free cycle. The waveform is unchanged and no second sequence follows.
- R8: `scl_oe` and `sda_oe` never both change in the same cycle.
- R9: A reset during a sequence releases both lines on the next cycle and returns the block to idle. A later trigger then runs a complete sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Start request, sampled when idle |
| fast_mode | input | 1 | 1 selects the fast timing set, 0 the slow set |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The hardest case to reach from the ports is a trigger that lands in the very last bus-free cycle. At that point the sequencer is one edge from idle, so an off-by-one in the busy window would quietly start a second sequence. The stimulus places a trigger at every class of position: the first running cycle, the middle of the clock train, and exactly the last bus-free cycle. Each run is compared cycle by cycle against a waveform computed from the counts, in both speed modes. Mid-sequence mode flips and a mid-sequence reset are compared the same way.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

    localparam int unsigned DUR_W      = 16;
    localparam int unsigned NUM_CLOCKS = 9;

    typedef logic [DUR_W-1:0] dur_t;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SETUP_A,
        PH_HOLD_A,
        PH_DROP,
        PH_LOW,
        PH_HIGH,
        PH_SETUP_B,
        PH_HOLD_B,
        PH_STOP_SU,
        PH_FREE
    } phase_e;

    typedef struct packed {
        dur_t low;
        dur_t high;
        dur_t su_sta;
        dur_t hd_sta;
        dur_t su_sto;
        dur_t free;
    } timing_t;

    typedef struct packed {
        logic scl_pull;
        logic sda_pull;
    } lines_t;

    // Line levels held during each phase (1 = pulled low).
    function automatic lines_t phase_lines(phase_e ph);
        lines_t l;
        l = '{scl_pull: 1'b0, sda_pull: 1'b0};
        case (ph)
            PH_HOLD_A, PH_HOLD_B, PH_STOP_SU: l.sda_pull = 1'b1;
            PH_DROP:                          l = '{scl_pull: 1'b1, sda_pull: 1'b1};
            PH_LOW:                           l.scl_pull = 1'b1;
            default:                          l = '{scl_pull: 1'b0, sda_pull: 1'b0};
        endcase
        return l;
    endfunction

    // Number of cycles spent in a phase.
    function automatic dur_t phase_len(phase_e ph, timing_t t);
        case (ph)
            PH_SETUP_A, PH_SETUP_B: return t.su_sta;
            PH_HOLD_A,  PH_HOLD_B:  return t.hd_sta;
            PH_LOW:                 return t.low;
            PH_HIGH:                return t.high;
            PH_STOP_SU:             return t.su_sto;
            PH_FREE:                return t.free;
            default:                return dur_t'(1);
        endcase
    endfunction

endpackage

// File: rtl/busrec_timing.sv
module busrec_timing
    import busrec_pkg::*;
#(
    parameter int unsigned SLOW_LOW  = 130,
    parameter int unsigned SLOW_HIGH = 60,
    parameter int unsigned SLOW_SU   = 60,
    parameter int unsigned SLOW_HD   = 60,
    parameter int unsigned SLOW_STO  = 60,
    parameter int unsigned SLOW_FREE = 130,
    parameter int unsigned FAST_LOW  = 60,
    parameter int unsigned FAST_HIGH = 40,
    parameter int unsigned FAST_SU   = 25,
    parameter int unsigned FAST_HD   = 25,
    parameter int unsigned FAST_STO  = 25,
    parameter int unsigned FAST_FREE = 50
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  logic    fast_in,
    output timing_t tim
);

    localparam timing_t SLOW_SET = '{
        low: dur_t'(SLOW_LOW), high: dur_t'(SLOW_HIGH), su_sta: dur_t'(SLOW_SU),
        hd_sta: dur_t'(SLOW_HD), su_sto: dur_t'(SLOW_STO), free: dur_t'(SLOW_FREE)};
    localparam timing_t FAST_SET = '{
        low: dur_t'(FAST_LOW), high: dur_t'(FAST_HIGH), su_sta: dur_t'(FAST_SU),
        hd_sta: dur_t'(FAST_HD), su_sto: dur_t'(FAST_STO), free: dur_t'(FAST_FREE)};

    logic mode_q;
    logic mode_eff;

    always_ff @(posedge clk) begin
        if (rst)       mode_q <= 1'b0;
        else if (load) mode_q <= fast_in;
    end

    // On the launch cycle the fresh mode is used so the first phase count is right.
    assign mode_eff = load ? fast_in : mode_q;
    assign tim      = mode_eff ? FAST_SET : SLOW_SET;

endmodule

// File: rtl/busrec_fsm.sv
module busrec_fsm
    import busrec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    trig,
    input  timing_t tim,
    output phase_e  phase,
    output phase_e  phase_nxt,
    output logic    launch,
    output logic    done
);

    localparam int unsigned CLK_W = $clog2(NUM_CLOCKS + 1);

    dur_t             cnt;
    logic [CLK_W-1:0] clk_idx;
    logic             expired;

    assign expired = (cnt == '0);
    assign launch  = (phase == PH_IDLE) && trig;

    always_comb begin
        phase_nxt = phase;
        case (phase)
            PH_IDLE:    if (trig)    phase_nxt = PH_SETUP_A;
            PH_SETUP_A: if (expired) phase_nxt = PH_HOLD_A;
            PH_HOLD_A:  if (expired) phase_nxt = PH_DROP;
            PH_DROP:    if (expired) phase_nxt = PH_LOW;
            PH_LOW:     if (expired) phase_nxt = PH_HIGH;
            PH_HIGH:    if (expired) phase_nxt = (clk_idx == CLK_W'(NUM_CLOCKS - 1))
                                                 ? PH_SETUP_B : PH_LOW;
            PH_SETUP_B: if (expired) phase_nxt = PH_HOLD_B;
            PH_HOLD_B:  if (expired) phase_nxt = PH_STOP_SU;
            PH_STOP_SU: if (expired) phase_nxt = PH_FREE;
            PH_FREE:    if (expired) phase_nxt = PH_IDLE;
            default:                 phase_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            clk_idx <= '0;
            done    <= 1'b0;
        end else begin
            phase <= phase_nxt;
            done  <= (phase == PH_FREE) && (phase_nxt == PH_IDLE);
            if (phase_nxt != phase)
                cnt <= phase_len(phase_nxt, tim) - dur_t'(1);
            else if (!expired)
                cnt <= cnt - dur_t'(1);
            if (phase == PH_HIGH && phase_nxt == PH_LOW)
                clk_idx <= clk_idx + CLK_W'(1);
            else if (phase_nxt == PH_IDLE)
                clk_idx <= '0;
        end
    end

    // R5: the end pulse lasts one cycle
    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: the end pulse only follows the bus-free interval
    a_r5_done_after_free: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(phase) == PH_FREE);

    // R7: a running sequence is never restarted
    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && phase != PH_SETUP_A) |=> phase != PH_SETUP_A);

    // R3: never more than nine clock pulses
    a_r3_clock_bound: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW) |-> clk_idx < CLK_W'(NUM_CLOCKS));

    // R6: timing set is frozen while a sequence runs
    a_r6_timing_frozen: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(tim));

endmodule

// File: rtl/busrec_lines.sv
module busrec_lines
    import busrec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase_nxt,
    output logic   scl_oe,
    output logic   sda_oe
);

    lines_t lvl_d;
    lines_t lvl_q;

    assign lvl_d = phase_lines(phase_nxt);

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '{scl_pull: 1'b0, sda_pull: 1'b0};
        else     lvl_q <= lvl_d;
    end

    assign scl_oe = lvl_q.scl_pull;
    assign sda_oe = lvl_q.sda_pull;

    // R8: at most one line moves per cycle
    a_r8_single_line_move: assert property (@(posedge clk) disable iff (rst)
        !((scl_oe != $past(scl_oe)) && (sda_oe != $past(sda_oe))));

    // R3: data line is released only while the clock line is held low
    a_r3_sda_release_under_low: assert property (@(posedge clk) disable iff (rst)
        ($fell(sda_oe) && $past(scl_oe)) |-> scl_oe);

endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq
    import busrec_pkg::*;
#(
    parameter int unsigned SLOW_LOW  = 130,
    parameter int unsigned SLOW_HIGH = 60,
    parameter int unsigned SLOW_SU   = 60,
    parameter int unsigned SLOW_HD   = 60,
    parameter int unsigned SLOW_STO  = 60,
    parameter int unsigned SLOW_FREE = 130,
    parameter int unsigned FAST_LOW  = 60,
    parameter int unsigned FAST_HIGH = 40,
    parameter int unsigned FAST_SU   = 25,
    parameter int unsigned FAST_HD   = 25,
    parameter int unsigned FAST_STO  = 25,
    parameter int unsigned FAST_FREE = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic fast_mode,
    output logic scl_oe,
    output logic sda_oe,
    output logic done
);

    timing_t tim;
    phase_e  phase;
    phase_e  phase_nxt;
    logic    launch;

    busrec_timing #(
        .SLOW_LOW(SLOW_LOW), .SLOW_HIGH(SLOW_HIGH), .SLOW_SU(SLOW_SU),
        .SLOW_HD(SLOW_HD), .SLOW_STO(SLOW_STO), .SLOW_FREE(SLOW_FREE),
        .FAST_LOW(FAST_LOW), .FAST_HIGH(FAST_HIGH), .FAST_SU(FAST_SU),
        .FAST_HD(FAST_HD), .FAST_STO(FAST_STO), .FAST_FREE(FAST_FREE)
    ) u_timing (
        .clk(clk), .rst(rst), .load(launch), .fast_in(fast_mode), .tim(tim)
    );

    busrec_fsm u_fsm (
        .clk(clk), .rst(rst), .trig(trig), .tim(tim),
        .phase(phase), .phase_nxt(phase_nxt), .launch(launch), .done(done)
    );

    busrec_lines u_lines (
        .clk(clk), .rst(rst), .phase_nxt(phase_nxt),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // R1: lines released while idle
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/bus_recovery_seq_tb.sv
module bus_recovery_seq_tb;

    localparam int S_LO = 130, S_HI = 60, S_SU = 60, S_HD = 60, S_SO = 60, S_BF = 130;
    localparam int F_LO = 60,  F_HI = 40, F_SU = 25, F_HD = 25, F_SO = 25, F_BF = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0;
    logic fast_mode = 1'b0;
    logic scl_oe, sda_oe, done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bus_recovery_seq u_dut (
        .clk(clk), .rst(rst), .trig(trig), .fast_mode(fast_mode),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done)
    );

    function automatic int total_len(input bit fm);
        if (fm) return F_SU + F_HD + 1 + 9 * (F_LO + F_HI) + F_SU + F_HD + F_SO + F_BF;
        return S_SU + S_HD + 1 + 9 * (S_LO + S_HI) + S_SU + S_HD + S_SO + S_BF;
    endfunction

    // Expected port values at sample k (k = 0 is the cycle after the accepting edge).
    function automatic void expect_at(input int k, input bit fm,
                                      output logic s, output logic d,
                                      output logic dn, output string tag);
        int lo, hi, su, hd, so, bf, b;
        lo = fm ? F_LO : S_LO; hi = fm ? F_HI : S_HI; su = fm ? F_SU : S_SU;
        hd = fm ? F_HD : S_HD; so = fm ? F_SO : S_SO; bf = fm ? F_BF : S_BF;
        s = 1'b0; d = 1'b0; dn = 1'b0; tag = "R2";
        if (k < su) return;
        b = su;
        if (k < b + hd) begin d = 1'b1; return; end
        b += hd;
        tag = "R3";
        if (k == b) begin s = 1'b1; d = 1'b1; return; end
        b += 1;
        for (int i = 0; i < 9; i++) begin
            if (k < b + lo) begin s = 1'b1; return; end
            b += lo;
            if (k < b + hi) return;
            b += hi;
        end
        tag = "R4";
        if (k < b + su) return;
        b += su;
        if (k < b + hd + so) begin d = 1'b1; return; end
        b += hd + so;
        tag = "R5";
        if (k < b + bf) return;
        b += bf;
        if (k == b) dn = 1'b1;
        else tag = "R1";
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp, input int k);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s k=%0d {scl_oe,sda_oe,done} actual=%b expected=%b", tag, k, act, exp);
        end
    endtask

    // poke: sample index after which trig is raised for one edge (-1 none)
    // flip: sample index after which fast_mode is inverted (-1 none)
    task automatic run_seq(input bit fm, input int poke, input int flip, input string why);
        int tot;
        logic s, d, dn;
        logic ps, pd;
        string tag;
        tot = total_len(fm);
        @(negedge clk);
        fast_mode = fm;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        ps = 1'b0; pd = 1'b0;
        for (int k = 0; k <= tot + 1; k++) begin
            expect_at(k, fm, s, d, dn, tag);
            // R6 / R7 runs compare against the undisturbed waveform
            check({tag, " ", why}, {scl_oe, sda_oe, done}, {s, d, dn}, k);
            if ((scl_oe !== ps) && (sda_oe !== pd)) begin
                checks++; fails++;
                $display("FAIL R8 k=%0d both lines moved: actual=%b%b expected one of them=%b%b",
                         k, scl_oe, sda_oe, ps, pd);
            end
            ps = scl_oe; pd = sda_oe;
            trig = (k == poke) ? 1'b1 : 1'b0;
            if (k == flip) fast_mode = ~fm;
            @(negedge clk);
        end
        trig = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 in reset", {scl_oe, sda_oe, done}, 3'b000, -1);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 idle", {scl_oe, sda_oe, done}, 3'b000, -1);

        // R2..R5 in both speed modes
        run_seq(1'b0, -1, -1, "slow");
        run_seq(1'b1, -1, -1, "fast");
        // R7: triggers while running, including the last bus-free cycle
        run_seq(1'b0, 0, -1, "R7 poke first cycle");
        run_seq(1'b1, 600, -1, "R7 poke mid clocks");
        run_seq(1'b0, total_len(1'b0) - 1, -1, "R7 poke last free cycle");
        run_seq(1'b1, total_len(1'b1) - 1, -1, "R7 poke last free cycle");
        // R6: mode changes during a sequence
        run_seq(1'b0, -1, 300, "R6 flip slow");
        run_seq(1'b1, -1, 10, "R6 flip fast");

        // R9: reset in mid sequence
        @(negedge clk);
        fast_mode = 1'b0;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (500) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 lines after reset", {scl_oe, sda_oe, done}, 3'b000, -1);
        repeat (3) @(negedge clk);
        check("R9 still idle", {scl_oe, sda_oe, done}, 3'b000, -1);
        run_seq(1'b1, -1, -1, "R9 restart");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule